// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a fast module clock into the 16x-oversampling strobe that a UART receiver and transmitter use to time their bits. The module clock first passes through a small integer predivider, chosen by a 3-bit coded field, which gives a reference enable once every 1 to 7 module cycles. A phase accumulator then runs on that reference. Each reference enable adds a programmable increment to the accumulator. When the accumulator passes a programmable modulus it wraps and emits one tick. The tick rate therefore satisfies tick_rate / reference_rate = (INC + 1) / (MOD + 1), which gives fine rate resolution from an arbitrary module clock.

A second counter, also run from the reference enable, emits a one-millisecond pulse after a programmed number of reference cycles. Software programs four values through a plain write port. Both outputs are single-cycle enables in the module clock domain, not derived clocks. The write port has no handshake: a write takes effect at the clock edge where `wr_en` is high.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset INC = 0, MOD = 0, the divider code is 5 (divide by 1) and the millisecond count is 0. The block therefore asserts `tick16` on every cycle from the first edge after reset, and `ms_tick` stays low.
- R2: The 3-bit divider code selects the divide value as follows: code 0 = 6, 1 = 5, 2 = 4, 3 = 3, 4 = 2, 5 = 1, and codes 6 and 7 both = 7.
- R3: With divide value N, the reference enable fires once every N module cycles. The first enable after a rate write comes N cycles after the write edge.
- R4: On each reference enable the accumulator adds INC+1. When the sum reaches MOD+1 or more, the block subtracts MOD+1, so over (MOD+1) reference enables with INC ≤ MOD it emits exactly INC+1 ticks.
- R5: When INC is greater than MOD, every reference enable produces a tick and the accumulator stays at zero.
- R6: `tick16` is high for one module-clock cycle, registered on the same edge at which the reference enable is taken. It is low on all cycles without a reference enable.
- R7: A write to the control, INC or MOD register clears the divider counter, the accumulator and `tick16` on that edge. The new values govern from the next cycle.
- R8: In a control write only `wr_data[9:7]` (the divider code) is used. Every other bit of the written word has no effect on either output.
- R9: With millisecond count M ≠ 0, `ms_tick` pulses for one cycle on every M-th reference enable. M = 0 holds `ms_tick` low. A write to this register restarts the count.
- R10: `wr_sel` decodes as 0 = control, 1 = INC (`wr_data[15:0]`), 2 = MOD (`wr_data[15:0]`), 3 = millisecond count (`wr_data[MS_W-1:0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (R10) |
| wr_data | input | DATA_W | Write data |
| tick16 | output | 1 | 16x-baud single-cycle enable |
| ms_tick | output | 1 | One-millisecond single-cycle enable |

## Verification
The assertions check five things on every cycle:
- the accumulator never exceeds the programmed modulus;
- the divider counter stays within its range;
- each tick and each millisecond pulse follows a reference enable;
- a rate write leaves counter, accumulator and tick cleared on the next cycle.

The exact rates cannot be seen in a single cycle, and only the bench scenarios show them. These are the divide value for each code, the tick count over a full modulus period, the saturated behaviour when INC exceeds MOD, the millisecond period, and the fact that junk control bits do nothing. The bench shows them by comparing against a behavioural model on every clock and by counting ticks over exact windows.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_INC  = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_MS   = 2'd3
  } ubg_sel_e;

  localparam int CODE_LSB = 7;
  localparam logic [2:0] CODE_RESET = 3'd5;

  // divide value minus one for a divider code; codes 6 and 7 both give /7
  function automatic logic [2:0] div_m1_of(input logic [2:0] code);
    if (code >= 3'd6) return 3'd6;
    return 3'd5 - code;
  endfunction
endpackage

// File: rtl/ubg_regs.sv
module ubg_regs import ubg_pkg::*; #(
  parameter int DATA_W = 24,
  parameter int RATE_W = 16,
  parameter int MS_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2:0]        code_q,
  output logic [RATE_W-1:0] inc_q,
  output logic [RATE_W-1:0] mod_q,
  output logic [MS_W-1:0]   ms_q,
  output logic              clr_rate,
  output logic              clr_ms
);
  ubg_sel_e sel;
  assign sel      = ubg_sel_e'(wr_sel);
  assign clr_rate = wr_en && (sel != SEL_MS);
  assign clr_ms   = wr_en && (sel == SEL_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_RESET;
      inc_q  <= '0;
      mod_q  <= '0;
      ms_q   <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_CTRL: code_q <= wr_data[CODE_LSB +: 3];
        SEL_INC:  inc_q  <= wr_data[RATE_W-1:0];
        SEL_MOD:  mod_q  <= wr_data[RATE_W-1:0];
        SEL_MS:   ms_q   <= wr_data[MS_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/ubg_prediv.sv
module ubg_prediv import ubg_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] code,
  output logic       ref_en,
  output logic [2:0] cnt_q
);
  logic [2:0] lim;
  assign lim    = div_m1_of(code);
  assign ref_en = (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (ref_en) cnt_q <= '0;
    else             cnt_q <= cnt_q + 3'd1;
  end
endmodule

// File: rtl/ubg_frac.sv
module ubg_frac #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ref_en,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] modv,
  output logic         tick,
  output logic [W:0]   acc_q
);
  localparam int SW = W + 2;
  logic [SW-1:0] sum, modp, diff;

  assign sum  = {1'b0, acc_q} + {2'b00, inc} + SW'(1);
  assign modp = {2'b00, modv} + SW'(1);
  assign diff = sum - modp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (clr) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (ref_en) begin
      if (inc > modv) begin
        acc_q <= '0;
        tick  <= 1'b1;
      end else if (sum >= modp) begin
        acc_q <= diff[W:0];
        tick  <= 1'b1;
      end else begin
        acc_q <= sum[W:0];
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ubg_ms.sv
module ubg_ms #(
  parameter int MS_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            ref_en,
  input  logic [MS_W-1:0] ms_n,
  output logic            ms_tick
);
  logic [MS_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ms_tick <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      ms_tick <= 1'b0;
    end else if (ref_en && (ms_n != '0)) begin
      if (cnt >= ms_n - 1'b1) begin
        cnt     <= '0;
        ms_tick <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        ms_tick <= 1'b0;
      end
    end else begin
      ms_tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DATA_W = 24,
  parameter int RATE_W = 16,
  parameter int MS_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick16,
  output logic              ms_tick
);
  logic [2:0]        code_q, div_cnt;
  logic [RATE_W-1:0] inc_q, mod_q;
  logic [MS_W-1:0]   ms_q;
  logic              clr_rate, clr_ms, ref_en;
  logic [RATE_W:0]   acc_q;

  ubg_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W), .MS_W(MS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .code_q(code_q), .inc_q(inc_q), .mod_q(mod_q), .ms_q(ms_q),
    .clr_rate(clr_rate), .clr_ms(clr_ms)
  );

  ubg_prediv u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr_rate), .code(code_q),
    .ref_en(ref_en), .cnt_q(div_cnt)
  );

  ubg_frac #(.W(RATE_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .clr(clr_rate), .ref_en(ref_en),
    .inc(inc_q), .modv(mod_q), .tick(tick16), .acc_q(acc_q)
  );

  ubg_ms #(.MS_W(MS_W)) u_ms (
    .clk(clk), .rst_n(rst_n), .restart(clr_ms), .ref_en(ref_en),
    .ms_n(ms_q), .ms_tick(ms_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              tick16,
  input logic              ms_tick,
  input logic              ref_en,
  input logic [2:0]        div_cnt,
  input logic [RATE_W:0]   acc_q,
  input logic [RATE_W-1:0] mod_q
);
  // R4: the accumulator stays below MOD+1
  a_r4_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= {1'b0, mod_q});

  // R3: the divider counter never passes the largest divide value
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= 3'd6);

  // R6: a tick is always the result of a reference enable
  a_r6_tick_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    tick16 |-> $past(ref_en));

  // R9: a millisecond pulse is always the result of a reference enable
  a_r9_ms_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> $past(ref_en));

  // R7: a rate write clears counter, accumulator and tick
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 2'd3) |=> (!tick16 && div_cnt == 3'd0 && acc_q == '0));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .tick16(tick16), .ms_tick(ms_tick), .ref_en(ref_en),
  .div_cnt(div_cnt), .acc_q(acc_q), .mod_q(mod_q)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  localparam int DATA_W = 24;
  localparam int MS_W   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic tick16, ms_tick;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  baud_tick_gen #(.DATA_W(DATA_W), .MS_W(MS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick16(tick16), .ms_tick(ms_tick)
  );

  // behavioural reference model
  int m_code, m_inc, m_mod, m_ms, m_cnt, m_acc, m_mc, m_d;
  bit m_t, m_mt, m_r;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 5; m_inc = 0; m_mod = 0; m_ms = 0;
      m_cnt = 0; m_acc = 0; m_mc = 0; m_t = 0; m_mt = 0;
    end else begin
      m_d = (m_code >= 6) ? 7 : 6 - m_code;
      m_r = (m_cnt == m_d - 1);
      if (wr_en && wr_sel == 2'd3) begin m_mc = 0; m_mt = 0; end
      else if (m_r && m_ms != 0) begin
        if (m_mc >= m_ms - 1) begin m_mc = 0; m_mt = 1; end
        else begin m_mc++; m_mt = 0; end
      end else m_mt = 0;
      if (wr_en && wr_sel != 2'd3) begin m_cnt = 0; m_acc = 0; m_t = 0; end
      else begin
        m_cnt = m_r ? 0 : m_cnt + 1;
        if (m_r) begin
          if (m_inc > m_mod) begin m_acc = 0; m_t = 1; end
          else begin
            m_acc += m_inc + 1;
            if (m_acc >= m_mod + 1) begin m_acc -= m_mod + 1; m_t = 1; end
            else m_t = 0;
          end
        end else m_t = 0;
      end
      if (wr_en) case (wr_sel)
        2'd0: m_code = int'((wr_data >> 7) & 24'h7);
        2'd1: m_inc  = int'(wr_data[15:0]);
        2'd2: m_mod  = int'(wr_data[15:0]);
        default: m_ms = int'(wr_data[MS_W-1:0]);
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(tag, int'(tick16), int'(m_t));
      check(tag, int'(ms_tick), int'(m_mt));
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count(input int n, output int tc, output int mc);
    tc = 0; mc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tc += int'(tick16);
      mc += int'(ms_tick);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (10000 * 15) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int tc, mc;
    // R1: reset state, outputs low during reset
    repeat (3) @(negedge clk);
    check("R1", int'(tick16), 0);
    check("R1", int'(ms_tick), 0);
    rst_n = 1'b1;
    count(20, tc, mc);
    check("R1", tc, 20);
    check("R1", mc, 0);

    // R4 / R10: INC=2, MOD=15 at divide by 1 -> 30 ticks in 160 cycles
    tag = "R4";
    wreg(2'd1, 24'd2);
    wreg(2'd2, 24'd15);
    count(160, tc, mc);
    check("R4", tc, 30);

    // R2 / R3 / R8: every code with junk outside bits 9:7, INC=MOD=0
    tag = "R2";
    wreg(2'd1, 24'd0);
    wreg(2'd2, 24'd0);
    for (int c = 0; c < 8; c++) begin
      int dv;
      dv = (c >= 6) ? 7 : 6 - c;
      wreg(2'd0, (24'(c) << 7) | 24'hFFFC7F);
      count(840, tc, mc);
      check("R2", tc, 840 / dv);
    end

    // R3: first enable arrives N cycles after a rate write (code 2, /4)
    tag = "R3";
    wreg(2'd0, 24'd2 << 7);
    count(3, tc, mc);
    check("R3", tc, 0);
    count(1, tc, mc);
    check("R3", tc, 1);

    // R5: INC > MOD at /3 -> tick on every enable
    tag = "R5";
    wreg(2'd0, 24'd3 << 7);
    wreg(2'd1, 24'd9);
    wreg(2'd2, 24'd4);
    count(840, tc, mc);
    check("R5", tc, 280);

    // R7: rewrite mid-stream, then fractional ratio 5/7 at /2
    tag = "R7";
    wreg(2'd1, 24'd4);
    count(3, tc, mc);
    wreg(2'd2, 24'd6);
    wreg(2'd0, 24'd4 << 7);
    count(140, tc, mc);
    check("R7", tc, 50);

    // R9: millisecond count 5 at /2 -> one pulse per 10 cycles
    tag = "R9";
    wreg(2'd3, 24'd5);
    count(1000, tc, mc);
    check("R9", int'(mc >= 99 && mc <= 101), 1);
    wreg(2'd3, 24'd0);
    count(200, tc, mc);
    check("R9", mc, 0);

    // R6: single-cycle pulse at /7 with INC=MOD
    tag = "R6";
    wreg(2'd0, 24'd7 << 7);
    wreg(2'd1, 24'd0);
    wreg(2'd2, 24'd0);
    count(6, tc, mc);
    check("R6", tc, 0);
    count(2, tc, mc);
    check("R6", tc, 1);

    // R8: control write made of only junk bits equals code 0 (/6)
    tag = "R8";
    wreg(2'd0, 24'hFFFC7F);
    count(60, tc, mc);
    check("R8", tc, 10);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule